// File: doc/BRIEF.md
# Programmable 32-Source Interrupt Controller

The controller collects 32 interrupt inputs and reduces them to two processor request lines, one normal and one critical. Every input is first brought into the clock domain through a synchronizer chain. Each source can then be configured to latch on a transition or on an active level, and in either case the active sense can be inverted. Once a source is recognised, it is held in a pending (status) register until software clears it.

An enable register decides which pending sources are delivered. A routing register sends each delivered source to either the critical line or the normal line. A combinational priority encoder reports the number of the lowest-numbered delivered source, together with a valid flag, so that a handler can find its work without scanning the register.

Software reaches the state through a small register port. A write takes effect at the next clock edge. A read returns its data one cycle after the address is presented. In every register and on the input vector, source n sits at bit position 31-n, so source 0 is the most significant bit.

Top module: `intc32_ctrl`

## Requirements
- R1: Source n corresponds to bit 31-n of `src_in` and of every register. Register addresses are: 0 status, 1 enable, 2 route (1 = critical), 3 trigger, 4 sense, 5 masked status.
- R2: After reset, enable, route, trigger and status are all zero. Sense is all ones. `rd_data`, `irq_norm`, `irq_crit` and `top_vld` are low.
- R3: When the trigger bit is 1 (edge mode), the status bit is set once for each selected transition: rising when the sense bit is 1, falling when it is 0. The bit is set at the third clock edge after the input changes.
- R4: When the trigger bit is 0 (level mode), the status bit is set while the input is at its active level: high when the sense bit is 1, low when it is 0.
- R5: Writing status clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing all ones clears every source that is not re-asserting.
- R6: Clearing a level-mode source whose input is still active has no lasting effect. The bit reads back as set, whether or not the source is enabled.
- R7: When a new edge and a clear of the same bit happen in the same cycle, the bit ends up set.
- R8: A disabled source still latches into status. Masked status (address 5) reads status AND enable. It is read-only, and a write to it changes no register.
- R9: `irq_norm` is high when any masked-status bit with route 0 is set. `irq_crit` is high when any masked-status bit with route 1 is set.
- R10: `top_id` gives the lowest-numbered source with a masked-status bit set, and `top_vld` is high. When no such bit is set, `top_vld` is 0 and `top_id` is 0.
- R11: Addresses 6 and 7 read as zero, and writes to them are ignored. `rd_data` shows the register addressed at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32 | Raw interrupt inputs, source n on bit 31-n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Registered read data |
| irq_norm | output | 1 | Normal interrupt request |
| irq_crit | output | 1 | Critical interrupt request |
| top_id | output | 5 | Lowest-numbered delivered source |
| top_vld | output | 1 | A delivered source exists |

## Verification
The assertions assume that `wr_en` and the addresses are never unknown once reset has been released. They also assume that software clears status after changing trigger or sense, because such a change can latch a spurious source. The stimulus keeps to these rules: it drives every input from a known value at the falling edge, and it follows every configuration change with a full status clear before it checks anything. Input changes on `src_in` are held for several cycles, so the bench never depends on a pulse shorter than the synchronizer can capture.

// File: rtl/intc32_pkg.sv
package intc32_pkg;
  typedef enum logic [2:0] {
    RA_STAT  = 3'd0,
    RA_ENAB  = 3'd1,
    RA_ROUTE = 3'd2,
    RA_TRIG  = 3'd3,
    RA_SENSE = 3'd4,
    RA_MSTAT = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/intc32_src_cond.sv
module intc32_src_cond #(
  parameter int N    = 32,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_in,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] sense,
  output logic [N-1:0] set_o
);
  logic [N-1:0] stg [SYNC];
  logic [N-1:0] prev;
  logic [N-1:0] cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < SYNC; k++) stg[k] <= '0;
      prev <= '0;
    end else begin
      stg[0] <= src_in;
      for (int k = 1; k < SYNC; k++) stg[k] <= stg[k-1];
      prev <= stg[SYNC-1];
    end
  end

  assign cur = stg[SYNC-1];

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic lvl_hit;
    logic edg_hit;
    assign lvl_hit  = sense[i] ? cur[i] : ~cur[i];
    assign edg_hit  = sense[i] ? (cur[i] & ~prev[i]) : (~cur[i] & prev[i]);
    assign set_o[i] = trig[i] ? edg_hit : lvl_hit;
  end
endmodule

// File: rtl/intc32_stat_bank.sv
module intc32_stat_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sr_o
);
  always_ff @(posedge clk) begin
    if (rst) sr_o <= '0;
    else     sr_o <= (sr_o & ~clr_i) | set_i;
  end

  // R5
  clr_done_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sr_o & $past(clr_i & ~set_i)) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sr_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/intc32_prio.sv
module intc32_prio #(
  parameter int N   = 32,
  parameter int IDW = $clog2(N)
) (
  input  logic [N-1:0]   vec,
  output logic [IDW-1:0] id,
  output logic           vld
);
  always_comb begin
    id  = '0;
    vld = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) begin
        id  = IDW'(N - 1 - i);
        vld = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc32_ctrl.sv
module intc32_ctrl
  import intc32_pkg::*;
#(
  parameter int N    = 32,
  parameter int SYNC = 2,
  localparam int IDW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   src_in,
  input  logic           wr_en,
  input  logic [2:0]     wr_addr,
  input  logic [N-1:0]   wr_data,
  input  logic [2:0]     rd_addr,
  output logic [N-1:0]   rd_data,
  output logic           irq_norm,
  output logic           irq_crit,
  output logic [IDW-1:0] top_id,
  output logic           top_vld
);
  logic [N-1:0] er, cr, tr, pr;
  logic [N-1:0] sr, msr, set_v, clr_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      er <= '0;
      cr <= '0;
      tr <= '0;
      pr <= '1;
    end else if (wr_en) begin
      case (wr_addr)
        RA_ENAB:  er <= wr_data;
        RA_ROUTE: cr <= wr_data;
        RA_TRIG:  tr <= wr_data;
        RA_SENSE: pr <= wr_data;
        default: ;
      endcase
    end
  end

  assign clr_v = (wr_en && wr_addr == RA_STAT) ? wr_data : '0;

  intc32_src_cond #(.N(N), .SYNC(SYNC)) cond_i (
    .clk(clk), .rst(rst), .src_in(src_in),
    .trig(tr), .sense(pr), .set_o(set_v)
  );

  intc32_stat_bank #(.N(N)) stat_i (
    .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr_v), .sr_o(sr)
  );

  assign msr      = sr & er;
  assign irq_norm = |(msr & ~cr);
  assign irq_crit = |(msr & cr);

  intc32_prio #(.N(N), .IDW(IDW)) prio_i (
    .vec(msr), .id(top_id), .vld(top_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        RA_STAT:  rd_data <= sr;
        RA_ENAB:  rd_data <= er;
        RA_ROUTE: rd_data <= cr;
        RA_TRIG:  rd_data <= tr;
        RA_SENSE: rd_data <= pr;
        RA_MSTAT: rd_data <= msr;
        default:  rd_data <= '0;
      endcase
    end
  end

  // R2
  rst_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (er == '0 && cr == '0 && tr == '0 && sr == '0 && pr == '1));

  // R8
  mstat_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == RA_MSTAT) |=> $stable({er, cr, tr, pr}));

  // R10
  prio_hit_chk: assert property (@(posedge clk) disable iff (rst)
    top_vld |-> msr[N - 1 - int'(top_id)]);

  // R10
  prio_first_chk: assert property (@(posedge clk) disable iff (rst)
    top_vld |-> ((msr >> (N - int'(top_id))) == '0));

  // R10
  prio_none_chk: assert property (@(posedge clk) disable iff (rst)
    !top_vld |-> (msr == '0 && top_id == '0));
endmodule

// File: tb/intc32_ctrl_tb_top.sv
module intc32_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_in = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_norm, irq_crit, top_vld;
  logic [4:0]  top_id;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  intc32_ctrl dut_i (
    .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_norm(irq_norm), .irq_crit(irq_crit), .top_id(top_id), .top_vld(top_vld)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] sb(input int n);
    return 32'h1 << (31 - n);
  endfunction

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2 reset state
    rd(3'd0, v); chk("R2 status", v, 32'h0);
    rd(3'd1, v); chk("R2 enable", v, 32'h0);
    rd(3'd2, v); chk("R2 route", v, 32'h0);
    rd(3'd3, v); chk("R2 trigger", v, 32'h0);
    rd(3'd4, v); chk("R2 sense", v, 32'hffffffff);
    chk("R2 outputs", {29'h0, irq_norm, irq_crit, top_vld}, 32'h0);

    // R1 R4 R9 R10 single-source sweep, level high
    wr(3'd1, 32'hffffffff);
    for (int n = 0; n < 32; n++) begin
      src_in = sb(n); settle();
      chk("R10 id", {27'h0, top_id}, n);
      chk("R9 lines", {30'h0, irq_norm, irq_crit}, 32'h2);
      rd(3'd0, v); chk("R1 status bit", v, sb(n));
      src_in = '0; settle();
      wr(3'd0, 32'hffffffff);
      rd(3'd0, v); chk("R5 clear all", v, 32'h0);
    end

    // R10 R8 priority sweep with multiple pending
    for (int n = 0; n < 32; n++) begin
      src_in = 32'hffffffff >> n; settle();
      chk("R10 lowest id", {26'h0, top_vld, top_id}, {26'h0, 1'b1, 5'(n)});
      rd(3'd5, v); chk("R8 masked", v, 32'hffffffff >> n);
      src_in = '0; settle();
      wr(3'd0, 32'hffffffff);
    end
    chk("R10 none", {26'h0, top_vld, top_id}, 32'h0);

    // R9 routing
    wr(3'd2, 32'h0000ffff);
    src_in = sb(20); settle();
    chk("R9 critical", {30'h0, irq_norm, irq_crit}, 32'h1);
    src_in = sb(3); settle(); wr(3'd0, 32'hffffffff);
    chk("R9 normal", {30'h0, irq_norm, irq_crit}, 32'h2);
    src_in = '0; settle(); wr(3'd0, 32'hffffffff); wr(3'd2, 32'h0);

    // R8 R6 masked source still latches, clear has no lasting effect
    wr(3'd1, 32'h0);
    src_in = sb(7); settle();
    rd(3'd0, v); chk("R8 latched while disabled", v, sb(7));
    rd(3'd5, v); chk("R8 masked zero", v, 32'h0);
    chk("R8 no request", {30'h0, irq_norm, top_vld}, 32'h0);
    wr(3'd5, 32'hffffffff);
    rd(3'd1, v); chk("R8 masked write ignored", v, 32'h0);
    wr(3'd0, sb(7));
    rd(3'd0, v); chk("R6 level re-sets", v, sb(7));
    src_in = '0; settle(); wr(3'd0, 32'hffffffff);
    rd(3'd0, v); chk("R6 clears when inactive", v, 32'h0);

    // R4 active-low level
    wr(3'd4, ~sb(9)); settle(); wr(3'd0, 32'hffffffff);
    rd(3'd0, v); chk("R4 active low pending", v, sb(9));
    src_in = sb(9); settle(); wr(3'd0, 32'hffffffff);
    rd(3'd0, v); chk("R4 active low idle", v, 32'h0);
    src_in = '0; wr(3'd4, 32'hffffffff); settle(); wr(3'd0, 32'hffffffff);

    // R3 rising edge with latency
    wr(3'd1, 32'hffffffff);
    wr(3'd3, sb(12)); settle(); wr(3'd0, 32'hffffffff);
    @(negedge clk); src_in = sb(12);
    @(negedge clk); chk("R3 latency e1", {31'h0, top_vld}, 32'h0);
    @(negedge clk); chk("R3 latency e2", {31'h0, top_vld}, 32'h0);
    @(negedge clk); chk("R3 latency e3", {26'h0, top_vld, top_id}, {26'h0, 1'b1, 5'd12});
    settle(); wr(3'd0, sb(12)); settle();
    rd(3'd0, v); chk("R3 once per edge", v, 32'h0);
    // R5 write zero leaves pending
    src_in = '0; settle(); src_in = sb(12); settle();
    wr(3'd0, 32'h0);
    rd(3'd0, v); chk("R5 zero write", v, sb(12));
    wr(3'd0, sb(4));
    rd(3'd0, v); chk("R5 other bit write", v, sb(12));
    // R3 falling edge
    wr(3'd4, ~sb(12)); wr(3'd0, 32'hffffffff);
    rd(3'd0, v); chk("R3 falling idle", v, 32'h0);
    src_in = '0; settle();
    rd(3'd0, v); chk("R3 falling set", v, sb(12));
    wr(3'd4, 32'hffffffff); settle(); wr(3'd0, 32'hffffffff);

    // R7 new edge coincides with clear
    @(negedge clk); src_in = sb(12);
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd0; wr_data = sb(12);
    @(negedge clk); wr_en = 1'b0;
    rd(3'd0, v); chk("R7 set wins", v, sb(12));

    // R11 unused addresses
    wr(3'd6, 32'h12345678);
    rd(3'd6, v); chk("R11 unused read", v, 32'h0);
    rd(3'd1, v); chk("R11 write ignored", v, 32'hffffffff);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule